// File: doc/BRIEF.md
# Four-Channel Zone Classifier with Hysteresis

The block sorts four analog readings, given in millivolts, into one of five zones each. Every channel has four programmable bounds, in ascending order: low-low, low, high and high-high. A single hysteresis margin, also in millivolts, is shared by all four channels. Once a channel has a zone, the zone only moves when the reading clears a bound by more than that margin. Readings that wander around a bound therefore leave the reported zone alone.

A sample-valid strobe presents all four readings at once. A four-bit enable input selects which channels take part. A small write port loads the bounds and the margin. The result is a packed 16-bit status word: for each channel, a 3-bit zone code and a sticky flag that records a zone movement. Software reads the word and pulses a clear strobe to acknowledge the flags.

Top module: `zone_classifier`

## Requirements
- R1: After reset every zone code is 2 and every change flag is 0, so the status word reads 0x2222.
- R2: In the status word, channel k places its zone code in bits [4k+2:4k] and its change flag in bit 4k+3.
- R3: Zone codes are 0 (below low-low), 1 (low-low to low), 2 (low to high), 3 (high to high-high) and 4 (at or above high-high). Codes 5 to 7 never appear. The first enabled valid sample of a channel after reset sets its zone directly to the number of its bounds that the reading is greater than or equal to, with no margin applied.
- R4: After that first sample, a channel at zone L < 4 moves up only when the reading is strictly greater than bound L plus the margin. It then takes the number of bounds that the reading exceeds by more than the margin.
- R5: After that first sample, a channel at zone L > 0 moves down only when the reading plus the margin is strictly below bound L-1. It then takes the number of bounds b for which the reading plus the margin is greater than or equal to b.
- R6: A zone is held when neither condition is met, and it is held in every cycle without a sample-valid strobe.
- R7: Any change of a channel's zone sets that channel's change flag. The flag stays set until it is cleared.
- R8: A clear strobe clears every change flag whose channel does not change zone in that same cycle. A channel that changes zone in that cycle keeps its flag set.
- R9: A channel whose enable bit is 0 keeps its zone, never sets its flag and does not use up its first-sample direct setting.
- R10: A write takes effect from the next cycle. Address 4k+j loads bound j of channel k, where j = 0 is low-low, 1 is low, 2 is high and 3 is high-high. Address 16 loads the shared margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Readings on smp_mv are valid this cycle |
| smp_mv | input | 64 | Readings in millivolts, channel k in bits [16k+15:16k] |
| chan_en | input | 4 | Per-channel enable, bit k for channel k |
| cfg_we | input | 1 | Write strobe for bounds and margin |
| cfg_addr | input | 5 | Write address (see R10) |
| cfg_wdata | input | 16 | Write data in millivolts |
| stat_clr | input | 1 | Clear strobe for the change flags |
| status | output | 16 | Packed zone codes and change flags |

## Verification
The assertions assume that each channel's four bounds are programmed in ascending order. This ordering is what makes an upward move and a downward move exclusive, and it keeps the zone in a single band. They also assume that reset is applied before the first clock edge, so the history that the flag properties compare against starts at a known zone. The stimulus writes strictly ascending bounds for every channel, and later rewrites only the top bound to a value still above the one below it. Readings are chosen to sit just inside and just outside each bound plus or minus the margin, and also to jump across several zones in one sample.

// File: rtl/zc_pkg.sv
package zc_pkg;
    localparam int NUM_THR = 4;
    localparam int LVL_W   = 3;
    localparam int FIELD_W = LVL_W + 1;
    localparam logic [LVL_W-1:0] LVL_MID = 3'd2;
    localparam logic [LVL_W-1:0] LVL_TOP = 3'd4;

    typedef struct packed {
        logic             primed;
        logic [LVL_W-1:0] level;
        logic             flag;
    } chan_state_t;

    function automatic logic [LVL_W-1:0] hit_count(input logic [NUM_THR-1:0] hits);
        logic [LVL_W-1:0] n;
        n = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            n = n + {{(LVL_W-1){1'b0}}, hits[i]};
        end
        return n;
    endfunction
endpackage

// File: rtl/zc_cfg_regs.sv
module zc_cfg_regs import zc_pkg::*; #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int AW  = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [AW-1:0]                   addr_i,
    input  logic [DW-1:0]                   wdata_i,
    output logic [NCH*NUM_THR-1:0][DW-1:0]  thr_o,
    output logic [DW-1:0]                   hyst_o
);
    localparam int NBOUND = NCH * NUM_THR;

    typedef struct packed {
        logic [NBOUND-1:0][DW-1:0] thr;
        logic [DW-1:0]             hyst;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            for (int i = 0; i < NBOUND; i++) begin
                if (int'(addr_i) == i) cfg_d.thr[i] = wdata_i;
            end
            if (int'(addr_i) == NBOUND) cfg_d.hyst = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign thr_o  = cfg_q.thr;
    assign hyst_o = cfg_q.hyst;
endmodule

// File: rtl/zc_level_eval.sv
module zc_level_eval import zc_pkg::*; #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]               sample_i,
    input  logic [NUM_THR-1:0][DW-1:0]  thr_i,
    input  logic [DW-1:0]               hyst_i,
    input  logic [LVL_W-1:0]            cur_i,
    input  logic                        primed_i,
    output logic [LVL_W-1:0]            next_o
);
    localparam int EW = DW + 1;

    logic [NUM_THR-1:0] dir_hit, up_hit, dn_hit;
    logic [EW-1:0]      smp_ext, smp_plus;

    assign smp_ext  = {1'b0, sample_i};
    assign smp_plus = smp_ext + {1'b0, hyst_i};

    for (genvar j = 0; j < NUM_THR; j++) begin : g_cmp
        logic [EW-1:0] thr_ext, thr_plus;
        assign thr_ext    = {1'b0, thr_i[j]};
        assign thr_plus   = thr_ext + {1'b0, hyst_i};
        assign dir_hit[j] = smp_ext >= thr_ext;
        assign up_hit[j]  = smp_ext > thr_plus;
        assign dn_hit[j]  = smp_plus >= thr_ext;
    end

    logic [LVL_W-1:0] dir_lvl, up_lvl, dn_lvl;

    always_comb begin
        dir_lvl = hit_count(dir_hit);
        up_lvl  = hit_count(up_hit);
        dn_lvl  = hit_count(dn_hit);
        if (!primed_i)          next_o = dir_lvl;
        else if (up_lvl > cur_i) next_o = up_lvl;
        else if (dn_lvl < cur_i) next_o = dn_lvl;
        else                     next_o = cur_i;
    end
endmodule

// File: rtl/zc_chan_state.sv
module zc_chan_state import zc_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid_i,
    input  logic             enable_i,
    input  logic             clear_i,
    input  logic [LVL_W-1:0] next_level_i,
    output logic [LVL_W-1:0] level_o,
    output logic             flag_o,
    output logic             primed_o
);
    chan_state_t st_d, st_q;
    logic        take;

    assign take = sample_valid_i && enable_i;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.primed = 1'b1;
            st_d.level  = next_level_i;
        end
        if (st_d.level != st_q.level) st_d.flag = 1'b1;
        else if (clear_i)             st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{primed: 1'b0, level: LVL_MID, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign level_o  = st_q.level;
    assign flag_o   = st_q.flag;
    assign primed_o = st_q.primed;

    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_TOP);  // R3

    AST_HOLD_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(level_o));  // R6

    AST_MASK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !flag_o) |=> !flag_o);  // R9

    AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> flag_o);  // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clear_i) |=> flag_o);  // R7

    AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (flag_o == (level_o != $past(level_o))));  // R8
endmodule

// File: rtl/zone_classifier.sv
module zone_classifier import zc_pkg::*; #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int AW  = $clog2(NCH * NUM_THR + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic [NCH*DW-1:0]      smp_mv,
    input  logic [NCH-1:0]         chan_en,
    input  logic                   cfg_we,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [DW-1:0]          cfg_wdata,
    input  logic                   stat_clr,
    output logic [NCH*FIELD_W-1:0] status
);
    logic [NCH*NUM_THR-1:0][DW-1:0] cfg_thr;
    logic [DW-1:0]                  cfg_hyst;

    zc_cfg_regs #(.NCH(NCH), .DW(DW), .AW(AW)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .thr_o   (cfg_thr),
        .hyst_o  (cfg_hyst)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic [LVL_W-1:0] level_q, level_d;
        logic             flag_q, primed_q;

        zc_level_eval #(.DW(DW)) i_eval (
            .sample_i (smp_mv[k*DW +: DW]),
            .thr_i    (cfg_thr[k*NUM_THR +: NUM_THR]),
            .hyst_i   (cfg_hyst),
            .cur_i    (level_q),
            .primed_i (primed_q),
            .next_o   (level_d)
        );

        zc_chan_state i_state (
            .clk            (clk),
            .rst_n          (rst_n),
            .sample_valid_i (smp_valid),
            .enable_i       (chan_en[k]),
            .clear_i        (stat_clr),
            .next_level_i   (level_d),
            .level_o        (level_q),
            .flag_o         (flag_q),
            .primed_o       (primed_q)
        );

        assign status[k*FIELD_W +: FIELD_W] = {flag_q, level_q};
    end
endmodule

// File: tb/test_zone_classifier.sv
module test_zone_classifier;
    localparam int CLK_PERIOD = 8;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [63:0] smp_mv = '0;
    logic [3:0]  chan_en = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        stat_clr = 1'b0;
    logic [15:0] status;

    always #(CLK_PERIOD/2) clk = ~clk;

    zone_classifier i_zone_classifier (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
        .chan_en(chan_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .stat_clr(stat_clr), .status(status)
    );

    typedef struct { logic [15:0] exp; string tag; } item_t;
    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_lvl[NCH];
    bit m_flag[NCH];
    bit m_primed[NCH];
    int m_thr[NCH][4];
    int m_hyst;

    function automatic logic [15:0] model_word();
        logic [15:0] w = '0;
        for (int k = 0; k < NCH; k++) begin
            w[4*k +: 3] = 3'(m_lvl[k]);
            w[4*k+3]    = m_flag[k];
        end
        return w;
    endfunction

    task automatic push(input string tag);
        item_t it;
        it.exp = model_word();
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic step(input bit v, input int d0, input int d1, input int d2, input int d3,
                        input logic [3:0] en, input bit clr, input string tag);
        int d[NCH];
        d = '{d0, d1, d2, d3};
        @(negedge clk);
        smp_valid = v; chan_en = en; stat_clr = clr; cfg_we = 1'b0;
        for (int k = 0; k < NCH; k++) smp_mv[16*k +: 16] = 16'(d[k]);
        for (int k = 0; k < NCH; k++) begin
            int nl = m_lvl[k];
            if (v && en[k]) begin
                int dir = 0, up = 0, dn = 0;
                for (int j = 0; j < 4; j++) begin
                    if (d[k] >= m_thr[k][j]) dir++;
                    if (d[k] > m_thr[k][j] + m_hyst) up++;
                    if (d[k] + m_hyst >= m_thr[k][j]) dn++;
                end
                if (!m_primed[k])       nl = dir;
                else if (up > m_lvl[k]) nl = up;
                else if (dn < m_lvl[k]) nl = dn;
                m_primed[k] = 1;
            end
            if (nl != m_lvl[k]) m_flag[k] = 1;
            else if (clr)       m_flag[k] = 0;
            m_lvl[k] = nl;
        end
        push(tag);
    endtask

    task automatic wr(input int addr, input int val);
        @(negedge clk);
        smp_valid = 1'b0; stat_clr = 1'b0;
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 16'(val);
        if (addr < 16) m_thr[addr/4][addr%4] = val;
        else if (addr == 16) m_hyst = val;
        push("R10");
    endtask

    // monitor: compares after each active edge
    always @(posedge clk) begin
        item_t it;
        #2;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (status !== it.exp) begin
                errors++;
                $display("FAIL %s status actual=%h expected=%h", it.tag, status, it.exp);
            end
        end
    end

    initial begin
        for (int k = 0; k < NCH; k++) begin
            m_lvl[k] = 2; m_flag[k] = 0; m_primed[k] = 0;
            for (int j = 0; j < 4; j++) m_thr[k][j] = 0;
        end
        m_hyst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        step(0, 0, 0, 0, 0, 4'hF, 0, "R1");
        for (int k = 0; k < NCH; k++)
            for (int j = 0; j < 4; j++) wr(4*k + j, 1000*(j+1) + 100*k);
        wr(16, 50);

        step(1, 500, 2500, 3500, 5000, 4'b0111, 0, "R3 R9");
        step(0, 0, 0, 0, 0, 4'hF, 1, "R8");
        step(1, 1030, 2500, 3500, 5000, 4'b0111, 0, "R6");
        step(1, 1051, 2500, 3500, 5000, 4'b0111, 0, "R4");
        step(1, 1051, 2500, 3160, 5000, 4'b0111, 0, "R6");
        step(1, 1051, 2500, 3149, 5000, 4'b0111, 0, "R5");
        step(1, 1051, 2500, 3149, 5000, 4'b0111, 1, "R8");
        step(1, 1051, 2500, 3149, 5000, 4'hF, 0, "R3 R9");
        step(1, 1051, 4200, 3149, 0, 4'hF, 1, "R8 R4 R5");
        step(0, 0, 0, 0, 4000, 4'hF, 0, "R6");
        step(1, 5000, 0, 5000, 5000, 4'b0000, 0, "R9");
        step(0, 0, 0, 0, 0, 4'hF, 1, "R8");
        step(0, 0, 0, 0, 0, 4'hF, 0, "R2 R7");
        wr(16, 0);
        step(1, 2001, 4200, 2199, 0, 4'hF, 0, "R10 R4 R5");
        wr(7, 4300);
        step(1, 2001, 4200, 2199, 0, 4'hF, 0, "R10 R5");
        step(1, 2001, 4200, 2199, 0, 4'hF, 0, "R2 R7");

        @(negedge clk);
        smp_valid = 1'b0; cfg_we = 1'b0; stat_clr = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule